// File: doc/BRIEF.md
# Machine-Cycle and Peripheral Tick Generator

This block runs entirely on one oscillator clock and turns it into five single-cycle enable strobes. The strobes are a machine-cycle strobe, a general timer tick, a baud-generator tick for the second timer, a shift tick for synchronous serial mode and a bit tick for the fixed-rate asynchronous serial mode. Downstream logic uses these strobes as clock enables, so every consumer stays in the oscillator clock domain.

A 2-bit divide code and a 2x/4x multiplier select set the machine-cycle length. The three peripheral mode bits choose between a fixed divider and the machine-cycle rate for the timer and shift ticks, and they halve the serial bit period. The power-saving code stretches every strobe by a large factor. A new setting is held back until the machine cycle in progress ends. At that moment every divider restarts together, so the strobes begin again in phase.

Top module: `mc_tick_gen`

## Requirements
- R1: While `rst` is high all five strobes are low. After reset the block behaves as divide code 2'b10 with all mode bits 0, so the first `mc_stb` appears on the third clock cycle after `rst` falls.
- R2: `mc_stb` repeats every 1 cycle for code 2'b00 with `mult_4x`=1, every 2 cycles for code 2'b00 with `mult_4x`=0, every 4 cycles for code 2'b10 and every `PMM_DIV` (default 1024) cycles for code 2'b11.
- R3: With `tmr_mc_rate`=0, `tmr_tick` repeats every 12 cycles in codes 2'b00 and 2'b10 and every 3*`PMM_DIV` cycles in code 2'b11. With `tmr_mc_rate`=1 it fires in exactly the cycles in which `mc_stb` fires.
- R4: `baud_tick` repeats every 2 cycles in codes 2'b00 and 2'b10 and every `PMM_DIV`/2 cycles in code 2'b11.
- R5: With `ser0_mc_rate`=0, `ser0_tick` repeats every three machine cycles (3, 6, 12 or 3*`PMM_DIV` oscillator cycles). With `ser0_mc_rate`=1 it fires in exactly the cycles in which `mc_stb` fires.
- R6: `ser2_tick` repeats every 64 cycles, or every 32 with `ser2_double`=1, in codes 2'b00 and 2'b10. In code 2'b11 it repeats every 16*`PMM_DIV` cycles, or 8*`PMM_DIV` with `ser2_double`=1.
- R7: The reserved code 2'b01 produces the same strobe periods as code 2'b10.
- R8: A change on any setting input is adopted only at the end of the machine cycle in progress. That cycle keeps its old length, and the next machine cycle has the new length.
- R9: When a new setting is adopted, every divider restarts from zero. The first peripheral tick after the change therefore comes one full new period after the adoption point.
- R10: Each strobe is high for one cycle per period, so a strobe whose period exceeds 1 is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| div_code | input | 2 | Clock-divide code: 00 multiplier, 01 reserved, 10 divide-by-four, 11 power-saving |
| mult_4x | input | 1 | Multiplier select for code 00: 1 = one cycle per machine cycle, 0 = two |
| tmr_mc_rate | input | 1 | Timer tick runs at the machine-cycle rate when 1 |
| ser0_mc_rate | input | 1 | Serial shift tick runs at the machine-cycle rate when 1 |
| ser2_double | input | 1 | Halves the serial bit-tick period when 1 |
| mc_stb | output | 1 | Machine-cycle strobe |
| tmr_tick | output | 1 | General timer tick |
| baud_tick | output | 1 | Second-timer baud-generator tick |
| ser0_tick | output | 1 | Synchronous serial shift tick |
| ser2_tick | output | 1 | Fixed-rate serial bit tick |

## Verification
The bound checker watches on every cycle that the held setting changes only directly after a machine-cycle strobe, and that the timer and shift ticks coincide with the machine-cycle strobe whenever they are set to its rate. It also checks that the baud and serial bit ticks, and the power-saving machine strobe, are never high twice in a row. The exact period of each strobe under each code and mode combination is shown only by the bench's measurements. The same holds for the old machine cycle finishing at its old length, the phase restart after a change, and the reserved code matching divide-by-four.

// File: rtl/tick_pkg.sv
package tick_pkg;

    localparam int NCH = 5;

    typedef enum logic [2:0] {
        CH_MC   = 3'd0,
        CH_TMR  = 3'd1,
        CH_BAUD = 3'd2,
        CH_SER0 = 3'd3,
        CH_SER2 = 3'd4
    } chan_e;

    typedef enum logic [1:0] {
        DIV_MULT = 2'b00,
        DIV_RSVD = 2'b01,
        DIV_QUAD = 2'b10,
        DIV_PMM  = 2'b11
    } div_e;

    typedef struct packed {
        div_e code;
        logic x4;
        logic tmr_fast;
        logic ser0_fast;
        logic ser2_dbl;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{code: DIV_QUAD, x4: 1'b0, tmr_fast: 1'b0,
                                   ser0_fast: 1'b0, ser2_dbl: 1'b0};

    localparam int unsigned QUAD_DIV     = 4;
    localparam int unsigned TMR_FIXED    = 12;
    localparam int unsigned BAUD_FIXED   = 2;
    localparam int unsigned SER0_MULT    = 3;
    localparam int unsigned SER2_FIXED   = 64;
    localparam int unsigned PMM_TMR_MULT = 3;
    localparam int unsigned PMM_SER2_MUL = 16;

    function automatic int unsigned mc_period(cfg_t c, int unsigned pmm);
        case (c.code)
            DIV_MULT: return c.x4 ? 1 : 2;
            DIV_PMM:  return pmm;
            default:  return QUAD_DIV;
        endcase
    endfunction

    function automatic int unsigned chan_period(chan_e ch, cfg_t c, int unsigned pmm);
        int unsigned mc;
        int unsigned s2;
        logic slow;
        mc   = mc_period(c, pmm);
        slow = (c.code == DIV_PMM);
        case (ch)
            CH_MC:   return mc;
            CH_TMR:  return c.tmr_fast ? mc : (slow ? PMM_TMR_MULT * pmm : TMR_FIXED);
            CH_BAUD: return slow ? pmm / 2 : BAUD_FIXED;
            CH_SER0: return c.ser0_fast ? mc : SER0_MULT * mc;
            default: begin
                s2 = slow ? PMM_SER2_MUL * pmm : SER2_FIXED;
                return c.ser2_dbl ? s2 / 2 : s2;
            end
        endcase
    endfunction

endpackage

// File: rtl/tick_cfg_hold.sv
module tick_cfg_hold
    import tick_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mc_tick,
    input  cfg_t cfg_in,
    output cfg_t cfg_q,
    output logic apply
);

    // A differing request is taken only on the last cycle of a machine cycle.
    assign apply = mc_tick && (cfg_in != cfg_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (apply) begin
            cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/tick_rate_table.sv
module tick_rate_table
    import tick_pkg::*;
#(
    parameter int unsigned PMM_DIV = 1024,
    parameter int          PW      = 15
) (
    input  cfg_t                     cfg,
    output logic [NCH-1:0][PW-1:0]   per
);

    for (genvar g = 0; g < NCH; g++) begin : g_rate
        assign per[g] = PW'(chan_period(chan_e'(g), cfg, PMM_DIV));
    end

endmodule

// File: rtl/tick_div_counter.sv
module tick_div_counter #(
    parameter int PW = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [PW-1:0] period,
    output logic          tick
);

    localparam logic [PW-1:0] ONE = PW'(1);

    logic [PW-1:0] cnt;

    assign tick = (cnt == period - ONE);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + ONE;
        end
    end

endmodule

// File: rtl/mc_tick_gen.sv
module mc_tick_gen
    import tick_pkg::*;
#(
    parameter int unsigned PMM_DIV = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] div_code,
    input  logic       mult_4x,
    input  logic       tmr_mc_rate,
    input  logic       ser0_mc_rate,
    input  logic       ser2_double,
    output logic       mc_stb,
    output logic       tmr_tick,
    output logic       baud_tick,
    output logic       ser0_tick,
    output logic       ser2_tick
);

    // Widest period is the slow serial bit tick in power-saving mode.
    localparam int PW = $clog2(PMM_SER2_MUL * PMM_DIV) + 1;

    cfg_t                   cfg_in;
    cfg_t                   cfg_q;
    logic                   apply;
    logic [NCH-1:0][PW-1:0] per;
    logic [NCH-1:0]         tick_vec;

    always_comb begin
        cfg_in.code      = div_e'(div_code);
        cfg_in.x4        = mult_4x;
        cfg_in.tmr_fast  = tmr_mc_rate;
        cfg_in.ser0_fast = ser0_mc_rate;
        cfg_in.ser2_dbl  = ser2_double;
    end

    tick_cfg_hold u_cfg (
        .clk     (clk),
        .rst     (rst),
        .mc_tick (tick_vec[CH_MC]),
        .cfg_in  (cfg_in),
        .cfg_q   (cfg_q),
        .apply   (apply)
    );

    tick_rate_table #(.PMM_DIV(PMM_DIV), .PW(PW)) u_rate (
        .cfg (cfg_q),
        .per (per)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_div
        tick_div_counter #(.PW(PW)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .restart (apply),
            .period  (per[g]),
            .tick    (tick_vec[g])
        );
    end

    assign mc_stb    = tick_vec[CH_MC];
    assign tmr_tick  = tick_vec[CH_TMR];
    assign baud_tick = tick_vec[CH_BAUD];
    assign ser0_tick = tick_vec[CH_SER0];
    assign ser2_tick = tick_vec[CH_SER2];

endmodule

// File: rtl/mc_tick_gen_chk.sv
module mc_tick_gen_chk
    import tick_pkg::*;
(
    input logic clk,
    input logic rst,
    input cfg_t cfg_q,
    input logic mc_stb,
    input logic tmr_tick,
    input logic baud_tick,
    input logic ser0_tick,
    input logic ser2_tick
);

    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    AST_RESET_DEFAULT: assert property (@(posedge clk)
        rst |=> (cfg_q.code == DIV_QUAD));  // R1

    AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$stable(cfg_q)) |-> $past(mc_stb));  // R8

    AST_TMR_FOLLOWS_MC: assert property (@(posedge clk) disable iff (rst)
        cfg_q.tmr_fast |-> (tmr_tick == mc_stb));  // R3

    AST_SER0_FOLLOWS_MC: assert property (@(posedge clk) disable iff (rst)
        cfg_q.ser0_fast |-> (ser0_tick == mc_stb));  // R5

    AST_PMM_MC_SPACED: assert property (@(posedge clk) disable iff (rst)
        (past_ok && cfg_q.code == DIV_PMM && mc_stb) |-> !$past(mc_stb));  // R2

    AST_SER2_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ser2_tick |=> !ser2_tick);  // R10

    AST_BAUD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        baud_tick |=> !baud_tick);  // R10

endmodule

bind mc_tick_gen mc_tick_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_q     (cfg_q),
    .mc_stb    (mc_stb),
    .tmr_tick  (tmr_tick),
    .baud_tick (baud_tick),
    .ser0_tick (ser0_tick),
    .ser2_tick (ser2_tick)
);

// File: tb/tb_mc_tick_gen.sv
`timescale 1ns/1ps
module tb_mc_tick_gen;

    typedef struct packed {
        logic [1:0]  code;
        logic        x4;
        logic        txm;
        logic        sm2;
        logic        smod;
        int unsigned mc;
        int unsigned tmr;
        int unsigned baud;
        int unsigned s0;
        int unsigned s2;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'b10, 1'b0, 1'b0, 1'b0, 1'b0,    4,   12,   2,   12,    64},
        '{2'b10, 1'b0, 1'b1, 1'b1, 1'b1,    4,    4,   2,    4,    32},
        '{2'b00, 1'b1, 1'b0, 1'b0, 1'b0,    1,   12,   2,    3,    64},
        '{2'b00, 1'b1, 1'b1, 1'b1, 1'b1,    1,    1,   2,    1,    32},
        '{2'b00, 1'b0, 1'b0, 1'b0, 1'b1,    2,   12,   2,    6,    32},
        '{2'b00, 1'b0, 1'b1, 1'b1, 1'b0,    2,    2,   2,    2,    64},
        '{2'b01, 1'b0, 1'b0, 1'b1, 1'b0,    4,   12,   2,    4,    64},
        '{2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1024, 3072, 512, 3072, 16384},
        '{2'b11, 1'b1, 1'b1, 1'b1, 1'b1, 1024, 1024, 512, 1024,  8192}
    };
    localparam int WD_LIMIT = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] div_code = 2'b10;
    logic       mult_4x = 1'b0;
    logic       tmr_mc_rate = 1'b0;
    logic       ser0_mc_rate = 1'b0;
    logic       ser2_double = 1'b0;
    logic       mc_stb, tmr_tick, baud_tick, ser0_tick, ser2_tick;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int unsigned gap [5];
    bit dbl [5];
    string chan_tag [5] = '{"R2", "R3", "R4", "R5", "R6"};

    mc_tick_gen dut (
        .clk          (clk),
        .rst          (rst),
        .div_code     (div_code),
        .mult_4x      (mult_4x),
        .tmr_mc_rate  (tmr_mc_rate),
        .ser0_mc_rate (ser0_mc_rate),
        .ser2_double  (ser2_double),
        .mc_stb       (mc_stb),
        .tmr_tick     (tmr_tick),
        .baud_tick    (baud_tick),
        .ser0_tick    (ser0_tick),
        .ser2_tick    (ser2_tick)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic check(string tag, int unsigned act, int unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive a setting, then wait for a machine-cycle strobe so it is adopted.
    task automatic settle(vec_t v);
        @(negedge clk);
        div_code     = v.code;
        mult_4x      = v.x4;
        tmr_mc_rate  = v.txm;
        ser0_mc_rate = v.sm2;
        ser2_double  = v.smod;
        do @(negedge clk); while (!mc_stb);
    endtask

    // Interval between the first two ticks of each strobe within the window.
    task automatic measure(int unsigned win);
        int  t1 [5];
        bit  s1 [5];
        bit  s2 [5];
        bit  prv [5];
        logic [4:0] cur;
        for (int c = 0; c < 5; c++) begin
            t1[c] = 0; s1[c] = 0; s2[c] = 0; prv[c] = 0; gap[c] = 0; dbl[c] = 0;
        end
        for (int i = 0; i < int'(win); i++) begin
            @(negedge clk);
            cur = {ser2_tick, ser0_tick, baud_tick, tmr_tick, mc_stb};
            for (int c = 0; c < 5; c++) begin
                if (cur[c]) begin
                    if (prv[c]) dbl[c] = 1'b1;
                    if (!s1[c]) begin
                        s1[c] = 1'b1;
                        t1[c] = i;
                    end else if (!s2[c]) begin
                        s2[c] = 1'b1;
                        gap[c] = int'(i - t1[c]);
                    end
                end
                prv[c] = cur[c];
            end
        end
    endtask

    initial begin
        int unsigned n;
        int unsigned exp [5];
        bit dbl_bad;

        // R1: outputs low in reset, default divide-by-four afterwards
        repeat (4) @(negedge clk);
        check("R1 strobes in reset",
              {27'd0, mc_stb, tmr_tick, baud_tick, ser0_tick, ser2_tick}, 0);
        rst = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!mc_stb && n < 10);
        check("R1 first mc_stb cycle", n, 3);

        // Table of settings: periods of every strobe (R2..R7, R10)
        for (int k = 0; k < NV; k++) begin
            settle(VECS[k]);
            measure(2 * VECS[k].s2 + 4);
            exp = '{VECS[k].mc, VECS[k].tmr, VECS[k].baud, VECS[k].s0, VECS[k].s2};
            dbl_bad = 1'b0;
            for (int c = 0; c < 5; c++) begin
                check(chan_tag[c], gap[c], exp[c]);
                if (exp[c] > 1 && dbl[c]) dbl_bad = 1'b1;
            end
            check("R10 single-cycle pulses", dbl_bad, 0);
            if (VECS[k].code == 2'b01) check("R7 reserved code mc period", gap[0], 4);
        end

        // R8: request mid machine cycle; old cycle finishes, then new length
        settle(VECS[0]);
        do @(negedge clk); while (!mc_stb);
        @(negedge clk);
        div_code = 2'b11;
        n = 1;
        do begin
            @(negedge clk);
            n++;
        end while (!mc_stb);
        check("R8 old machine cycle kept", n, 4);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!mc_stb);
        check("R8 new machine cycle length", n, 1024);

        // R9: change 20 cycles after a serial bit tick; divider restarts
        settle(VECS[0]);
        do @(negedge clk); while (!ser2_tick);
        repeat (20) @(negedge clk);
        div_code = 2'b00;
        mult_4x  = 1'b1;
        n = 20;
        do begin
            @(negedge clk);
            n++;
        end while (!ser2_tick);
        check("R9 serial tick gap across restart", n, 84);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule